// File: doc/BRIEF.md
# Long-Descriptor Page Table Walker

This block translates a virtual address by walking a page table made of 64-bit long-format descriptors, over up to four lookup levels numbered 0 to 3. A request carries the virtual address, the physical base of the first table, the level the walk begins at, a granule selector (4 KB, 16 KB or 64 KB) and the physical address width in force. The walker fetches one descriptor per level through a simple read port. It follows table entries downward until a block or page entry ends the walk, or until a fault stops it.

While it descends, the walker gathers the permission limits that table entries place on everything below them. It ORs each of these limits into a running set. On a successful walk it reports the output address, the size of the offset taken from the virtual address, the attribute fields of the final entry and the gathered table limits. On a failed walk it reports the kind of fault and the level at which it occurred. All results stay on the outputs until the next request is accepted. Filling a TLB, decoding the attribute index and updating the access flag are left to the blocks around it.

Top module: `ldesc_walker`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req` are 0 and `fault` is 0 (none).
- R2: A descriptor whose bits [1:0] are 11, read at level 0, 1 or 2, is a table entry. The next read targets descriptor bits [47:g] with zeros below, ORed with the virtual address index shifted left by 3. Here g is the granule width (12, 14 or 16 for `gran_sel` 0, 1, 2), the stride s is g-3, the index for level L is VA[lo+s-1:lo] and lo = s*(3-L)+g. The first read uses the same rule on `tbl_base` at `start_lvl`.
- R3: Bits [1:0] = 11 at level 3 are a page entry, and `off_bits` equals g.
- R4: Bits [1:0] = 01 are a block entry only for a 4 KB granule at level 1 (`off_bits` 30) or level 2 (21), or for a 16 KB or 64 KB granule at level 2 (25 or 29). At any other level or granule the entry gives a translation fault.
- R5: Bits [1:0] = 00 or 10 give a translation fault (`fault` = 1), and `fault_lvl` holds the level of the descriptor that was read.
- R6: `out_addr` is descriptor bits [47:n] joined to VA bits [n-1:0], where n is `off_bits`.
- R7: The final-entry fields come from fixed descriptor bits: execute-never from 54, privileged execute-never from 53, contiguous from 52, not-global from 11, access flag from 10, shareability from [9:8], access permission from [7:6], non-secure from 5 and attribute index from [4:2].
- R8: The table limits are taken from every table entry: non-secure from bit 63, access limit from [62:61], execute-never from 60 and privileged execute-never from 59. Each one is ORed into `acc_*` and, once set, stays set until the walk ends.
- R9: When `high_el` is 1, `leaf_global` is 1 whatever bit 11 holds. Otherwise `leaf_global` is the inverse of bit 11.
- R10: When `out_addr` has any bit set at or above position `pa_bits`, the walk ends with an address-size fault (`fault` = 2) at the level of the final entry.
- R11: Each level issues exactly one single-cycle `rd_req`, and each walk ends with a single-cycle `done`. A `gran_sel` of 3 ends the walk at once with a translation fault at `start_lvl` and no read.
- R12: A `start` that arrives while a walk is in progress has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk; accepted only when idle |
| va | input | VA_W | Virtual address to translate |
| tbl_base | input | PA_W | Physical base of the first table |
| start_lvl | input | 2 | Level the walk begins at |
| gran_sel | input | 2 | Granule: 0 = 4 KB, 1 = 16 KB, 2 = 64 KB, 3 = illegal |
| high_el | input | 1 | Walk runs for one of the two highest privilege levels |
| pa_bits | input | 6 | Physical address width in force |
| rd_req | output | 1 | Single-cycle descriptor read request |
| rd_addr | output | PA_W | Descriptor address, valid with rd_req |
| rd_valid | input | 1 | Read data is present this cycle |
| rd_data | input | 64 | Descriptor returned by memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Single-cycle end-of-walk strobe |
| fault | output | 2 | 0 none, 1 translation, 2 address size |
| fault_lvl | output | 2 | Level at which the fault arose |
| out_addr | output | PA_W | Translated address |
| off_bits | output | 6 | Width of the offset taken from the VA |
| leaf_xn | output | 1 | Execute-never |
| leaf_pxn | output | 1 | Privileged execute-never |
| leaf_contig | output | 1 | Contiguous hint |
| leaf_global | output | 1 | Translation is global |
| leaf_af | output | 1 | Access flag |
| leaf_sh | output | 2 | Shareability |
| leaf_ap | output | 2 | Access permission |
| leaf_attr | output | 3 | Attribute index |
| leaf_ns | output | 1 | Non-secure output address |
| acc_ns | output | 1 | Gathered table non-secure limit |
| acc_ap | output | 2 | Gathered table access limit |
| acc_xn | output | 1 | Gathered table execute-never |
| acc_pxn | output | 1 | Gathered table privileged execute-never |

## Verification
On every cycle the assertions check that read requests and the completion strobe last one cycle, that reads happen only during a walk, and that the gathered table limits never clear once set while a walk is running. At each completion they also check that a successful result has a legal offset width, fits within the configured physical width, and is reported as global for high-privilege walks. Only the bench scenarios can show the rest: the index bit positions for each granule and level, which block entries are legal, the fault levels, the exact field positions, the lack of any read for the illegal granule, and that a second start during a walk is ignored. They do so by planting descriptors at the addresses the rule predicts and comparing the results.

// File: rtl/lwk_pkg.sv
package lwk_pkg;

  localparam int DESC_W = 64;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_XLAT  = 2'd1,
    FK_ASIZE = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    DK_INVALID = 2'd0,
    DK_TABLE   = 2'd1,
    DK_LEAF    = 2'd2
  } dkind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  // granule selector to offset width in bits
  function automatic logic [5:0] gran_width(input logic [1:0] g);
    case (g)
      2'd1:    gran_width = 6'd14;
      2'd2:    gran_width = 6'd16;
      default: gran_width = 6'd12;
    endcase
  endfunction

endpackage

// File: rtl/lwk_index.sv
// Forms the address of the descriptor to fetch at a given level.
module lwk_index
  import lwk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] base,
  input  logic [1:0]      level,
  input  logic [1:0]      gran,
  output logic [PA_W-1:0] desc_addr
);

  logic [5:0]      gw;
  logic [5:0]      stride;
  logic [6:0]      lo;
  logic [VA_W-1:0] imask;
  logic [VA_W-1:0] idx;

  always_comb begin
    gw        = gran_width(gran);
    stride    = gw - 6'd3;
    // index low bit: stride * (3 - level) + granule width
    lo        = 7'(stride) * 7'(2'd3 - level) + 7'(gw);
    imask     = (VA_W'(1) << stride) - VA_W'(1);
    idx       = (va >> lo) & imask;
    desc_addr = base | (PA_W'(idx) << 3);
  end

endmodule

// File: rtl/lwk_classify.sv
// Decides what a fetched descriptor is and derives its addresses.
module lwk_classify
  import lwk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input  logic [PA_W-1:0] desc_lo,
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      level,
  input  logic [1:0]      gran,
  output dkind_e          kind,
  output logic [5:0]      offw,
  output logic [PA_W-1:0] leaf_addr,
  output logic [PA_W-1:0] next_base
);

  logic [5:0]      gw;
  logic [PA_W-1:0] nmask;
  logic [PA_W-1:0] gmask;

  always_comb begin
    gw   = gran_width(gran);
    kind = DK_INVALID;
    offw = 6'd0;
    if (gran != 2'd3) begin
      if (desc_lo[1:0] == 2'b11) begin
        if (level == 2'd3) begin
          kind = DK_LEAF;
          offw = gw;
        end else begin
          kind = DK_TABLE;
        end
      end else if (desc_lo[1:0] == 2'b01) begin
        if (gran == 2'd0) begin
          if (level == 2'd1) begin
            kind = DK_LEAF;
            offw = 6'd30;
          end else if (level == 2'd2) begin
            kind = DK_LEAF;
            offw = 6'd21;
          end
        end else if (level == 2'd2) begin
          kind = DK_LEAF;
          offw = (gran == 2'd1) ? 6'd25 : 6'd29;
        end
      end
    end
    nmask     = (PA_W'(1) << offw) - PA_W'(1);
    gmask     = (PA_W'(1) << gw) - PA_W'(1);
    leaf_addr = (desc_lo & ~nmask) | (PA_W'(va) & nmask);
    next_base = desc_lo & ~gmask;
  end

endmodule

// File: rtl/ldesc_walker.sv
module ldesc_walker
  import lwk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] tbl_base,
  input  logic [1:0]      start_lvl,
  input  logic [1:0]      gran_sel,
  input  logic            high_el,
  input  logic [5:0]      pa_bits,
  output logic            rd_req,
  output logic [PA_W-1:0] rd_addr,
  input  logic            rd_valid,
  input  logic [63:0]     rd_data,
  output logic            busy,
  output logic            done,
  output logic [1:0]      fault,
  output logic [1:0]      fault_lvl,
  output logic [PA_W-1:0] out_addr,
  output logic [5:0]      off_bits,
  output logic            leaf_xn,
  output logic            leaf_pxn,
  output logic            leaf_contig,
  output logic            leaf_global,
  output logic            leaf_af,
  output logic [1:0]      leaf_sh,
  output logic [1:0]      leaf_ap,
  output logic [2:0]      leaf_attr,
  output logic            leaf_ns,
  output logic            acc_ns,
  output logic [1:0]      acc_ap,
  output logic            acc_xn,
  output logic            acc_pxn
);

  state_e          state;
  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] base_q;
  logic [1:0]      lvl_q;
  logic [1:0]      gran_q;
  logic            hel_q;
  logic [5:0]      pab_q;

  logic [PA_W-1:0] idx_addr;
  dkind_e          kind;
  logic [5:0]      offw;
  logic [PA_W-1:0] leaf_addr;
  logic [PA_W-1:0] next_base;
  logic            asize_bad;
  logic            unused_desc;

  assign unused_desc = ^{rd_data[58:55], rd_data[51:48]};

  lwk_index #(.VA_W(VA_W), .PA_W(PA_W)) u_index (
    .va        (va_q),
    .base      (base_q),
    .level     (lvl_q),
    .gran      (gran_q),
    .desc_addr (idx_addr)
  );

  lwk_classify #(.VA_W(VA_W), .PA_W(PA_W)) u_class (
    .desc_lo   (rd_data[PA_W-1:0]),
    .va        (va_q),
    .level     (lvl_q),
    .gran      (gran_q),
    .kind      (kind),
    .offw      (offw),
    .leaf_addr (leaf_addr),
    .next_base (next_base)
  );

  always_comb begin
    asize_bad = 1'b0;
    if (32'(pab_q) < PA_W)
      asize_bad = ((leaf_addr >> pab_q) != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      lvl_q       <= '0;
      gran_q      <= '0;
      hel_q       <= 1'b0;
      pab_q       <= '0;
      rd_req      <= 1'b0;
      rd_addr     <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      fault       <= FK_NONE;
      fault_lvl   <= '0;
      out_addr    <= '0;
      off_bits    <= '0;
      leaf_xn     <= 1'b0;
      leaf_pxn    <= 1'b0;
      leaf_contig <= 1'b0;
      leaf_global <= 1'b0;
      leaf_af     <= 1'b0;
      leaf_sh     <= '0;
      leaf_ap     <= '0;
      leaf_attr   <= '0;
      leaf_ns     <= 1'b0;
      acc_ns      <= 1'b0;
      acc_ap      <= '0;
      acc_xn      <= 1'b0;
      acc_pxn     <= 1'b0;
    end else begin
      done   <= 1'b0;
      rd_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            va_q    <= va;
            base_q  <= tbl_base;
            lvl_q   <= start_lvl;
            gran_q  <= gran_sel;
            hel_q   <= high_el;
            pab_q   <= pa_bits;
            acc_ns  <= 1'b0;
            acc_ap  <= '0;
            acc_xn  <= 1'b0;
            acc_pxn <= 1'b0;
            fault   <= FK_NONE;
            if (gran_sel == 2'd3) begin
              fault     <= FK_XLAT;
              fault_lvl <= start_lvl;
              done      <= 1'b1;
            end else begin
              busy  <= 1'b1;
              state <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          rd_addr <= idx_addr;
          rd_req  <= 1'b1;
          state   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_valid) begin
            case (kind)
              DK_TABLE: begin
                base_q  <= next_base;
                lvl_q   <= lvl_q + 2'd1;
                acc_ns  <= acc_ns | rd_data[63];
                acc_ap  <= acc_ap | rd_data[62:61];
                acc_xn  <= acc_xn | rd_data[60];
                acc_pxn <= acc_pxn | rd_data[59];
                state   <= ST_ADDR;
              end
              DK_LEAF: begin
                out_addr    <= leaf_addr;
                off_bits    <= offw;
                leaf_xn     <= rd_data[54];
                leaf_pxn    <= rd_data[53];
                leaf_contig <= rd_data[52];
                leaf_global <= hel_q | ~rd_data[11];
                leaf_af     <= rd_data[10];
                leaf_sh     <= rd_data[9:8];
                leaf_ap     <= rd_data[7:6];
                leaf_ns     <= rd_data[5];
                leaf_attr   <= rd_data[4:2];
                fault       <= asize_bad ? FK_ASIZE : FK_NONE;
                fault_lvl   <= lvl_q;
                done        <= 1'b1;
                busy        <= 1'b0;
                state       <= ST_IDLE;
              end
              default: begin
                fault     <= FK_XLAT;
                fault_lvl <= lvl_q;
                done      <= 1'b1;
                busy      <= 1'b0;
                state     <= ST_IDLE;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: read requests and completion strobes last a single cycle
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  // R8: gathered table limits never clear during a walk
  p_sticky_xn_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(acc_xn)) |-> acc_xn);
  p_sticky_ap_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (($past(acc_ap) & ~acc_ap) == 2'b00));

  // R4: successful walks end with a legal offset width
  p_offset_legal_r4: assert property (@(posedge clk) disable iff (rst)
    (done && fault == FK_NONE) |->
      (off_bits inside {6'd12, 6'd14, 6'd16, 6'd21, 6'd25, 6'd29, 6'd30}));

  // R9: high-privilege walks report global translations
  p_global_r9: assert property (@(posedge clk) disable iff (rst)
    (done && fault == FK_NONE && hel_q) |-> leaf_global);

  // R10: a successful result fits the configured physical width
  p_asize_r10: assert property (@(posedge clk) disable iff (rst)
    (done && fault == FK_NONE && (32'(pab_q) < PA_W)) |->
      ((out_addr >> pab_q) == '0));

endmodule

// File: tb/ldesc_walker_test.sv
module ldesc_walker_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [47:0] va = '0;
  logic [47:0] tbl_base = '0;
  logic [1:0]  start_lvl = '0;
  logic [1:0]  gran_sel = '0;
  logic        high_el = 1'b0;
  logic [5:0]  pa_bits = 6'd48;
  logic        rd_req;
  logic [47:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic        busy, done;
  logic [1:0]  fault, fault_lvl;
  logic [47:0] out_addr;
  logic [5:0]  off_bits;
  logic        leaf_xn, leaf_pxn, leaf_contig, leaf_global, leaf_af, leaf_ns;
  logic [1:0]  leaf_sh, leaf_ap;
  logic [2:0]  leaf_attr;
  logic        acc_ns, acc_xn, acc_pxn;
  logic [1:0]  acc_ap;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  logic [63:0] mem [logic [47:0]];

  always #5 clk = ~clk;

  ldesc_walker uut (
    .clk(clk), .rst(rst), .start(start), .va(va), .tbl_base(tbl_base),
    .start_lvl(start_lvl), .gran_sel(gran_sel), .high_el(high_el),
    .pa_bits(pa_bits), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .fault(fault), .fault_lvl(fault_lvl), .out_addr(out_addr),
    .off_bits(off_bits), .leaf_xn(leaf_xn), .leaf_pxn(leaf_pxn),
    .leaf_contig(leaf_contig), .leaf_global(leaf_global),
    .leaf_af(leaf_af), .leaf_sh(leaf_sh), .leaf_ap(leaf_ap),
    .leaf_attr(leaf_attr), .leaf_ns(leaf_ns), .acc_ns(acc_ns),
    .acc_ap(acc_ap), .acc_xn(acc_xn), .acc_pxn(acc_pxn)
  );

  // memory model: two idle cycles, then one cycle of data
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        logic [47:0] a;
        a = rd_addr;
        nreads++;
        repeat (2) @(negedge clk);
        rd_data  = mem.exists(a) ? mem[a] : 64'd0;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // descriptor address predicted from the R2 rule
  function automatic logic [47:0] daddr(input logic [47:0] base,
      input logic [47:0] v, input int lvl, input int g);
    int s;
    int lo;
    logic [47:0] m;
    s  = g - 3;
    lo = s * (3 - lvl) + g;
    m  = (48'd1 << s) - 48'd1;
    return base | (((v >> lo) & m) << 3);
  endfunction

  task automatic run(input logic [47:0] v, input logic [47:0] b,
                     input logic [1:0] lv, input logic [1:0] gr,
                     input logic h, input logic [5:0] pb);
    int t;
    nreads = 0;
    @(negedge clk);
    va = v; tbl_base = b; start_lvl = lv; gran_sel = gr;
    high_el = h; pa_bits = pb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1, "R11 walk completes", 64'(done), 64'd1);
    @(negedge clk);
    chk_eq("R11 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk_eq("R1 busy after reset", 64'(busy), 64'd0);
    chk_eq("R1 done after reset", 64'(done), 64'd0);
    chk_eq("R1 rd_req after reset", 64'(rd_req), 64'd0);
    chk_eq("R1 fault after reset", 64'(fault), 64'd0);
  endtask

  task automatic t_four_level_4k;
    logic [47:0] v;
    v = 48'h1234_5678_9ABC;
    mem.delete();
    mem[daddr(48'h10_0000, v, 0, 12)] = 64'h1000_0000_0020_0003;
    mem[daddr(48'h20_0000, v, 1, 12)] = 64'h2000_0000_0030_0003;
    mem[daddr(48'h30_0000, v, 2, 12)] = 64'h0000_0000_0040_0003;
    mem[daddr(48'h40_0000, v, 3, 12)] = 64'h0050_0000_8765_4E77;
    run(v, 48'h10_0000, 2'd0, 2'd0, 1'b0, 6'd48);
    chk_eq("R2 four reads for four levels", 64'(nreads), 64'd4);
    chk_eq("R3 page fault none", 64'(fault), 64'd0);
    chk_eq("R3 page offset 12", 64'(off_bits), 64'd12);
    chk_eq("R6 page output addr", 64'(out_addr), 64'h8765_4ABC);
    chk_eq("R7 xn", 64'(leaf_xn), 64'd1);
    chk_eq("R7 pxn", 64'(leaf_pxn), 64'd0);
    chk_eq("R7 contig", 64'(leaf_contig), 64'd1);
    chk_eq("R9 not-global when low privilege", 64'(leaf_global), 64'd0);
    chk_eq("R7 af", 64'(leaf_af), 64'd1);
    chk_eq("R7 sh", 64'(leaf_sh), 64'd2);
    chk_eq("R7 ap", 64'(leaf_ap), 64'd1);
    chk_eq("R7 ns", 64'(leaf_ns), 64'd1);
    chk_eq("R7 attr index", 64'(leaf_attr), 64'd5);
    chk_eq("R8 xn stays set after level 0", 64'(acc_xn), 64'd1);
    chk_eq("R8 ap gathered", 64'(acc_ap), 64'd1);
    chk_eq("R8 pxn clear", 64'(acc_pxn), 64'd0);
    chk_eq("R8 ns clear", 64'(acc_ns), 64'd0);
  endtask

  task automatic t_blocks;
    logic [47:0] v;
    v = 48'h7F12_3456_789A;
    mem.delete();
    mem[daddr(48'h50_0000, v, 1, 12)] = 64'h0000_00C0_0000_0401;
    run(v, 48'h50_0000, 2'd1, 2'd0, 1'b0, 6'd48);
    chk_eq("R4 4K level1 block offset 30", 64'(off_bits), 64'd30);
    chk_eq("R6 level1 block addr", 64'(out_addr),
           64'(48'hC0_0000_0000 | (v & 48'h3FFF_FFFF)));
    chk_eq("R9 global when bit11 clear", 64'(leaf_global), 64'd1);
    mem.delete();
    mem[daddr(48'h51_0000, v, 2, 12)] = 64'h0000_0000_7FE0_0801;
    run(v, 48'h51_0000, 2'd2, 2'd0, 1'b1, 6'd48);
    chk_eq("R4 4K level2 block offset 21", 64'(off_bits), 64'd21);
    chk_eq("R6 level2 block addr", 64'(out_addr),
           64'(48'h7FE0_0000 | (v & 48'h1F_FFFF)));
    chk_eq("R9 high privilege forces global", 64'(leaf_global), 64'd1);
  endtask

  task automatic t_big_granules;
    logic [47:0] v;
    v = 48'h5A5A_1234_CDEF;
    mem.delete();
    mem[daddr(48'h60_0000, v, 1, 14)] = 64'h0800_0000_0070_4003;
    mem[daddr(48'h70_4000, v, 2, 14)] = 64'h0000_0000_4200_0001;
    run(v, 48'h60_0000, 2'd1, 2'd1, 1'b0, 6'd48);
    chk_eq("R2 16K table then block reads", 64'(nreads), 64'd2);
    chk_eq("R4 16K level2 block offset 25", 64'(off_bits), 64'd25);
    chk_eq("R6 16K block addr", 64'(out_addr),
           64'(48'h4200_0000 | (v & 48'h1FF_FFFF)));
    chk_eq("R8 pxn from table", 64'(acc_pxn), 64'd1);
    mem.delete();
    mem[daddr(48'h80_0000, v, 2, 16)] = 64'h8000_0000_0090_0003;
    mem[daddr(48'h90_0000, v, 3, 16)] = 64'h0000_0001_2345_0003;
    run(v, 48'h80_0000, 2'd2, 2'd2, 1'b0, 6'd48);
    chk_eq("R3 64K page offset 16", 64'(off_bits), 64'd16);
    chk_eq("R6 64K page addr", 64'(out_addr),
           64'(48'h1_2345_0000 | (v & 48'hFFFF)));
    chk_eq("R8 ns from table", 64'(acc_ns), 64'd1);
    mem.delete();
    mem[daddr(48'hA0_0000, v, 2, 16)] = 64'h0000_0000_6000_0001;
    run(v, 48'hA0_0000, 2'd2, 2'd2, 1'b0, 6'd48);
    chk_eq("R4 64K level2 block offset 29", 64'(off_bits), 64'd29);
  endtask

  task automatic t_faults;
    logic [47:0] v;
    v = 48'h0123_4567_89AB;
    mem.delete();
    mem[daddr(48'hB0_0000, v, 0, 12)] = 64'h0000_0000_4000_0001;
    run(v, 48'hB0_0000, 2'd0, 2'd0, 1'b0, 6'd48);
    chk_eq("R4 4K level0 block faults", 64'(fault), 64'd1);
    chk_eq("R4 fault level 0", 64'(fault_lvl), 64'd0);
    mem.delete();
    mem[daddr(48'hB1_0000, v, 1, 14)] = 64'h0000_0000_4000_0001;
    run(v, 48'hB1_0000, 2'd1, 2'd1, 1'b0, 6'd48);
    chk_eq("R4 16K level1 block faults", 64'(fault), 64'd1);
    chk_eq("R4 fault level 1", 64'(fault_lvl), 64'd1);
    mem.delete();
    run(v, 48'hB2_0000, 2'd2, 2'd0, 1'b0, 6'd48);
    chk_eq("R5 zero descriptor faults", 64'(fault), 64'd1);
    chk_eq("R5 fault level 2", 64'(fault_lvl), 64'd2);
    mem[daddr(48'hB3_0000, v, 3, 12)] = 64'h0000_0000_1234_5002;
    run(v, 48'hB3_0000, 2'd3, 2'd0, 1'b0, 6'd48);
    chk_eq("R5 type 10 faults", 64'(fault), 64'd1);
    chk_eq("R5 fault level 3", 64'(fault_lvl), 64'd3);
  endtask

  task automatic t_addr_size;
    logic [47:0] v;
    v = 48'h0000_0012_3456;
    mem.delete();
    mem[daddr(48'hC0_0000, v, 2, 12)] = 64'h0000_0001_0000_0001;
    run(v, 48'hC0_0000, 2'd2, 2'd0, 1'b0, 6'd32);
    chk_eq("R10 address above 32-bit range faults", 64'(fault), 64'd2);
    chk_eq("R10 fault level", 64'(fault_lvl), 64'd2);
    run(v, 48'hC0_0000, 2'd2, 2'd0, 1'b0, 6'd33);
    chk_eq("R10 address inside 33-bit range ok", 64'(fault), 64'd0);
  endtask

  task automatic t_bad_granule;
    mem.delete();
    run(48'h1000, 48'hD0_0000, 2'd2, 2'd3, 1'b0, 6'd48);
    chk_eq("R11 granule 3 faults", 64'(fault), 64'd1);
    chk_eq("R11 granule 3 fault level", 64'(fault_lvl), 64'd2);
    chk_eq("R11 granule 3 makes no read", 64'(nreads), 64'd0);
  endtask

  task automatic t_start_busy;
    logic [47:0] v;
    int t;
    v = 48'h0000_4444_5555;
    mem.delete();
    mem[daddr(48'hE0_0000, v, 2, 12)] = 64'h0000_0000_0AE0_0001;
    nreads = 0;
    @(negedge clk);
    va = v; tbl_base = 48'hE0_0000; start_lvl = 2'd2; gran_sel = 2'd0;
    high_el = 1'b0; pa_bits = 6'd48; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    va = 48'h0000_0000_0000; tbl_base = 48'hF0_0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 500) begin
      @(negedge clk);
      t++;
    end
    chk_eq("R12 walk completes", 64'(done), 64'd1);
    chk_eq("R12 second start ignored", 64'(out_addr),
           64'(48'h0AE0_0000 | (v & 48'h1F_FFFF)));
    repeat (8) @(negedge clk);
    chk_eq("R12 no extra walk", 64'(nreads), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_four_level_4k();
    t_blocks();
    t_big_granules();
    t_faults();
    t_addr_size();
    t_bad_granule();
    t_start_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule